// File: doc/BRIEF.md
# Rotating-Register Frequency Quantizer Back End

This block is the digital half of an oscillator-based quantizer. It watches the level of several oscillator-derived edge streams, organised as groups that each carry one positive and one negative stream, and counts every rising transition of each stream on a fast system clock. Each stream drives its own five-element ring accumulator: an arriving edge flips the element under a rotating pointer and moves the pointer one step on. Once per conversion, a one-cycle sample tick freezes every accumulator state into a register pair, and a bitwise XOR of the newest and previous snapshots forms a thermometer-like output word.

Because consecutive edges always flip consecutive elements of the ring, the set bits in a stream's five-bit field equal the number of edges in that conversion period (up to five), and the bits that carry the count rotate from one period to the next, so mismatch between the downstream unit elements is averaged without any separate shuffling logic. An optional reduction adds up the positive fields and subtracts the negative fields of all groups into a signed binary word. A small warm-up state machine (states WARM_A, WARM_B, LIVE) flags the output as valid only once two sample ticks have followed reset: WARM_A moves to WARM_B on the first tick, WARM_B moves to LIVE on the second, and LIVE holds until reset.

Top module: `fdsm_therm_top`

## Requirements
- R1: While reset is asserted at a rising clock edge, every output bit is cleared after that edge: `therm_out` is zero, `diff_out` is zero and `out_valid` is low.
- R2: After reset is released, `out_valid` stays low through the first sample tick and rises on the clock edge of the second sample tick, then stays high until the next reset.
- R3: Each low-to-high transition of a stream level input is counted exactly once, provided the level holds for at least two clock cycles in each state.
- R4: Each counted edge toggles the accumulator element under that stream's pointer and advances the pointer by one, wrapping from element 4 to element 0; after reset every element is 0 and the pointer is at element 0.
- R5: Group g occupies bits 10g to 10g+4 of `therm_out` for its positive stream (element i at bit 10g+i) and bits 10g+5 to 10g+9 for its negative stream (element i at bit 10g+5+i); each field is the XOR of that accumulator's state captured at the last two sample ticks.
- R6: For 0 to 5 edges in one period, the number of set bits in the stream's field equals the number of edges.
- R7: `therm_out` only changes on the clock edge of a sample tick or reset.
- R8: `diff_out` is the two's-complement 5-bit value of the total set bits in all positive fields minus the total set bits in all negative fields.
- R9: An edge whose toggle falls on the same clock edge as a sample tick is left out of the snapshot taken at that tick and appears in the following period.
- R10: A reset applied in the middle of operation discards all pending edges, pointers and snapshots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | One-cycle sample tick marking a conversion boundary |
| pos_lvl | input | 3 | Positive edge-stream levels, one per group |
| neg_lvl | input | 3 | Negative edge-stream levels, one per group |
| therm_out | output | 30 | Differentiated accumulator word, ten bits per group |
| diff_out | output | 5 | Signed positive-minus-negative set-bit total |
| out_valid | output | 1 | High once two sample ticks have followed reset |

## Verification
The collision that matters is an edge toggling an accumulator on the very clock edge at which the sample tick captures it. The bench times a single rise on one positive stream so that its toggle lands on the tick edge, then expects a zero field in that period and a one-bit field, at the position the model pointer predicts, in the next. Every other period sweeps all 36 pairs of edge counts on the first group while the remaining groups follow an arithmetic pattern, and each field is compared exactly against a mask rebuilt from the bench's own pointer arithmetic.

// File: rtl/fdsm_pkg.sv
package fdsm_pkg;

    typedef enum logic [1:0] {
        WARM_A = 2'd0,
        WARM_B = 2'd1,
        LIVE   = 2'd2
    } warm_e;

endpackage

// File: rtl/fdsm_edge_sync.sv
module fdsm_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic pulse
);

    logic meta_q;
    logic sync_q;
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= lvl;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign pulse = sync_q & ~last_q;

endmodule

// File: rtl/fdsm_rot_acc.sv
module fdsm_rot_acc #(
    parameter int unsigned STAGES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [STAGES-1:0] state
);

    localparam int unsigned PW = (STAGES > 1) ? $clog2(STAGES) : 1;
    localparam logic [PW-1:0] LAST = PW'(STAGES - 1);

    logic [PW-1:0]     ptr_q;
    logic [STAGES-1:0] state_q;
    logic [STAGES-1:0] flip;

    always_comb begin
        flip = '0;
        for (int i = 0; i < STAGES; i++) begin
            flip[i] = step && (ptr_q == PW'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            state_q <= '0;
        end else if (step) begin
            state_q <= state_q ^ flip;
            ptr_q   <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/fdsm_diff_unit.sv
module fdsm_diff_unit #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else if (tick) begin
            cur_q  <= din;
            prev_q <= cur_q;
        end
    end

    assign dout = cur_q ^ prev_q;

endmodule

// File: rtl/fdsm_therm_top.sv
module fdsm_therm_top #(
    parameter int unsigned GROUPS = 3,
    parameter int unsigned STAGES = 5,
    parameter bit          BIN_EN = 1'b1,
    localparam int unsigned GW     = 2 * STAGES,
    localparam int unsigned OUT_W  = GROUPS * GW,
    localparam int unsigned DIFF_W = $clog2(GROUPS * STAGES + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_en,
    input  logic [GROUPS-1:0]        pos_lvl,
    input  logic [GROUPS-1:0]        neg_lvl,
    output logic [OUT_W-1:0]         therm_out,
    output logic signed [DIFF_W-1:0] diff_out,
    output logic                     out_valid
);

    import fdsm_pkg::*;

    logic [GROUPS-1:0] pos_pulse;
    logic [GROUPS-1:0] neg_pulse;
    logic [OUT_W-1:0]  acc_flat;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [STAGES-1:0] pos_state;
        logic [STAGES-1:0] neg_state;

        fdsm_edge_sync u_sync_p (
            .clk   (clk),
            .rst   (rst),
            .lvl   (pos_lvl[g]),
            .pulse (pos_pulse[g])
        );

        fdsm_edge_sync u_sync_n (
            .clk   (clk),
            .rst   (rst),
            .lvl   (neg_lvl[g]),
            .pulse (neg_pulse[g])
        );

        fdsm_rot_acc #(.STAGES(STAGES)) u_acc_p (
            .clk   (clk),
            .rst   (rst),
            .step  (pos_pulse[g]),
            .state (pos_state)
        );

        fdsm_rot_acc #(.STAGES(STAGES)) u_acc_n (
            .clk   (clk),
            .rst   (rst),
            .step  (neg_pulse[g]),
            .state (neg_state)
        );

        assign acc_flat[g*GW +: GW] = {neg_state, pos_state};

        fdsm_diff_unit #(.W(GW)) u_diff (
            .clk  (clk),
            .rst  (rst),
            .tick (sample_en),
            .din  ({neg_state, pos_state}),
            .dout (therm_out[g*GW +: GW])
        );
    end

    // warm-up sequencer
    warm_e warm_q;
    warm_e warm_nx;

    always_comb begin
        warm_nx = warm_q;
        unique case (warm_q)
            WARM_A:  if (sample_en) warm_nx = WARM_B;
            WARM_B:  if (sample_en) warm_nx = LIVE;
            LIVE:    warm_nx = LIVE;
            default: warm_nx = WARM_A;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) warm_q <= WARM_A;
        else     warm_q <= warm_nx;
    end

    always_comb begin
        out_valid = (warm_q == LIVE);
    end

    if (BIN_EN) begin : g_bin
        always_comb begin
            int psum;
            int nsum;
            psum = 0;
            nsum = 0;
            for (int g = 0; g < GROUPS; g++) begin
                for (int i = 0; i < STAGES; i++) begin
                    psum += int'(therm_out[g*GW + i]);
                    nsum += int'(therm_out[g*GW + STAGES + i]);
                end
            end
            diff_out = DIFF_W'(psum - nsum);
        end
    end else begin : g_nobin
        assign diff_out = '0;
    end

endmodule

// File: rtl/fdsm_therm_chk.sv
module fdsm_therm_chk #(
    parameter int unsigned GROUPS = 3,
    parameter int unsigned STAGES = 5,
    parameter bit          BIN_EN = 1'b1,
    parameter int unsigned OUT_W  = 30,
    parameter int unsigned DIFF_W = 5
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     sample_en,
    input logic [OUT_W-1:0]         therm_out,
    input logic signed [DIFF_W-1:0] diff_out,
    input logic                     out_valid,
    input logic [OUT_W-1:0]         acc_flat
);

    localparam int unsigned GW = 2 * STAGES;

    logic [GROUPS*STAGES-1:0] pos_bits;
    logic [GROUPS*STAGES-1:0] neg_bits;

    always_comb begin
        for (int g = 0; g < GROUPS; g++) begin
            pos_bits[g*STAGES +: STAGES] = therm_out[g*GW +: STAGES];
            neg_bits[g*STAGES +: STAGES] = therm_out[g*GW + STAGES +: STAGES];
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (therm_out == '0 && !out_valid)); // R1

    AST_VALID_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(sample_en)); // R2

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(therm_out)); // R7

    if (BIN_EN) begin : g_bin_chk
        AST_DIFF_MATCH: assert property (@(posedge clk) disable iff (rst)
            diff_out == DIFF_W'($countones(pos_bits) - $countones(neg_bits))); // R8
    end

    for (genvar a = 0; a < 2 * GROUPS; a++) begin : g_acc_chk
        AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
            $countones(acc_flat[a*STAGES +: STAGES] ^ $past(acc_flat[a*STAGES +: STAGES])) <= 1); // R4
    end

endmodule

bind fdsm_therm_top fdsm_therm_chk #(
    .GROUPS (GROUPS),
    .STAGES (STAGES),
    .BIN_EN (BIN_EN),
    .OUT_W  (OUT_W),
    .DIFF_W (DIFF_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .therm_out (therm_out),
    .diff_out  (diff_out),
    .out_valid (out_valid),
    .acc_flat  (acc_flat)
);

// File: tb/fdsm_therm_top_bench.sv
module fdsm_therm_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int G = 3;
    localparam int S = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sample_en = 1'b0;
    logic [G-1:0]      pos_lvl = '0;
    logic [G-1:0]      neg_lvl = '0;
    logic [G*2*S-1:0]  therm_out;
    logic signed [4:0] diff_out;
    logic              out_valid;

    int checks = 0;
    int errors = 0;
    int pp[G];
    int np[G];
    int cntp[G];
    int cntn[G];
    logic [G*2*S-1:0] held;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdsm_therm_top u_fdsm_therm_top (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .pos_lvl   (pos_lvl),
        .neg_lvl   (neg_lvl),
        .therm_out (therm_out),
        .diff_out  (diff_out),
        .out_valid (out_valid)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [S-1:0] ring_mask(input int ptr, input int k);
        logic [S-1:0] m;
        m = '0;
        for (int i = 0; i < k; i++) m[(ptr + i) % S] = 1'b1;
        return m;
    endfunction

    // expected word from the model pointers, then advance them
    task automatic expect_period(input string tag);
        logic [G*2*S-1:0] exp_w;
        int dsum;
        exp_w = '0;
        dsum = 0;
        for (int g = 0; g < G; g++) begin
            exp_w[g*2*S +: S]     = ring_mask(pp[g], cntp[g]);
            exp_w[g*2*S + S +: S] = ring_mask(np[g], cntn[g]);
            dsum += cntp[g] - cntn[g];
            check($countones(therm_out[g*2*S +: S]) == cntp[g], {tag, " R6 pos"},
                  $countones(therm_out[g*2*S +: S]), cntp[g]);
            check($countones(therm_out[g*2*S + S +: S]) == cntn[g], {tag, " R6 neg"},
                  $countones(therm_out[g*2*S + S +: S]), cntn[g]);
            pp[g] = (pp[g] + cntp[g]) % S;
            np[g] = (np[g] + cntn[g]) % S;
        end
        check(therm_out == exp_w, {tag, " R4 R5 word"}, therm_out, exp_w);
        check(int'(diff_out) == dsum, {tag, " R8 diff"}, int'(diff_out), dsum);
    endtask

    task automatic drive_edges();
        for (int e = 0; e < S; e++) begin
            @(negedge clk);
            for (int g = 0; g < G; g++) begin
                pos_lvl[g] = (cntp[g] > e);
                neg_lvl[g] = (cntn[g] > e);
            end
            @(negedge clk);
            @(negedge clk);
            pos_lvl = '0;
            neg_lvl = '0;
            @(negedge clk);
            @(negedge clk);
            check(therm_out == held, "R7 hold", therm_out, held);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk);
        sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0;
        held = therm_out;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(therm_out == '0, "R1 R10 word", therm_out, 0);
        check(diff_out == '0, "R1 diff", diff_out, 0);
        check(out_valid == 1'b0, "R1 valid", out_valid, 0);
        rst = 1'b0;
        for (int g = 0; g < G; g++) begin
            pp[g] = 0;
            np[g] = 0;
        end
        held = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        // warm-up: two ticks with no edges
        for (int g = 0; g < G; g++) begin
            cntp[g] = 0;
            cntn[g] = 0;
        end
        tick();
        check(out_valid == 1'b0, "R2 after first tick", out_valid, 0);
        expect_period("warm1");
        tick();
        check(out_valid == 1'b1, "R2 after second tick", out_valid, 1);
        expect_period("warm2");

        // sweep: group 0 takes every count pair, others follow a pattern (R3)
        for (int per = 0; per < 36; per++) begin
            cntp[0] = per % 6;
            cntn[0] = per / 6;
            for (int g = 1; g < G; g++) begin
                cntp[g] = (per * 5 + g * 2) % 6;
                cntn[g] = (per * 7 + g) % 6;
            end
            drive_edges();
            tick();
            expect_period("sweep R3");
            check(out_valid == 1'b1, "R2 stays", out_valid, 1);
        end

        // collision: toggle lands on the tick edge (R9)
        for (int g = 0; g < G; g++) begin
            cntp[g] = 0;
            cntn[g] = 0;
        end
        @(negedge clk);
        pos_lvl[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0;
        pos_lvl[0] = 1'b0;
        held = therm_out;
        expect_period("R9 same tick");
        cntp[0] = 1;
        repeat (4) @(negedge clk);
        tick();
        expect_period("R9 next period");

        // mid-run reset discards pending edges (R10)
        cntp[0] = 3;
        cntn[1] = 2;
        drive_edges();
        do_reset();
        for (int g = 0; g < G; g++) begin
            cntp[g] = 0;
            cntn[g] = 0;
        end
        tick();
        expect_period("R10 first");
        tick();
        expect_period("R10 second");
        cntp[0] = 1;
        cntn[2] = 5;
        drive_edges();
        tick();
        expect_period("R10 pointers restart");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule